// File: doc/BRIEF.md
# Configurable Logic-Cell Storage Register

This block is one storage cell for a product-term logic fabric. Static configuration inputs choose what it is. It can be a D, T, JK or SR flip-flop, or a plain wire that passes its combinational input to the output with no state.

The cell runs in one system clock, `clk`. Every "clock" it can pick is an ordinary signal sampled in that clock:

- either of two global clock sources, each built from any global clock pin in true or inverted form;
- the same global source, qualified by an active-high enable;
- a locally generated array clock.

The cell detects a rising edge of the chosen signal between two consecutive `clk` samples and advances its state on the `clk` edge where that rise is first seen.

Two local asynchronous controls act on the output at once, without waiting for any edge: an active-high clear and an active-high preset, both driven by product terms. A shared active-low global clear can be enabled per cell. A fast-input option replaces the logic-array data with a direct pin and makes the cell a D register.

The active-low synchronous reset stands in for device power-up. It loads a configured start value.

Configuration is static. Each time it changes, reset is applied.

Top module: `mcell_reg`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, the state loads `cfg_pwr_val`. With bypass off and no asynchronous control active, `q` then shows that value.
- R2: With `cfg_ff_type`=0 (D), each active clock edge sets the state to `lt_a`.
- R3: With `cfg_ff_type`=1 (T), an active edge inverts the state when `lt_a`=1 and keeps it when `lt_a`=0.
- R4: With `cfg_ff_type`=2 (JK, `lt_a`=J, `lt_b`=K), an active edge acts as follows: J=0,K=0 holds, J=1,K=0 sets, J=0,K=1 clears, and J=1,K=1 inverts.
- R5: With `cfg_ff_type`=3 (SR, `lt_a`=S, `lt_b`=R), an active edge acts as follows: S=1,R=0 sets, S=0,R=1 clears, and both 0 or both 1 hold.
- R6: With `cfg_bypass`=1, `q` equals `lt_a` in the same cycle. Clocks and asynchronous controls have no effect on it.
- R7: In clock modes 0 and 1, the active clock is global source `cfg_gsrc_sel`. Source g is `gclk_pin[cfg_src_pin[g]]`, XORed with `cfg_src_inv[g]`. The active edge is its 0-to-1 change between two `clk` samples, and the state updates at the `clk` edge where the 1 is first sampled.
- R8: In clock mode 1, an active edge seen while `clk_en` is 0 leaves the state unchanged.
- R9: In clock mode 2 or 3, only rising edges of `array_clk` clock the cell. The global pins are ignored.
- R10: `pt_clear`=1 forces `q` to 0 and `pt_preset`=1 forces `q` to 1, at once and without a clock edge. Clear wins when both are high. The forced value stays in the state after release.
- R11: With `cfg_gclr_en`=1, `gclr_n`=0 acts exactly like `pt_clear`. With `cfg_gclr_en`=0 it has no effect.
- R12: With `cfg_fast_in`=1, an active edge loads `fast_pin`, whatever the setting of `cfg_ff_type`. `lt_a` and `lt_b` are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling every clock source |
| rst_n | input | 1 | Active-low synchronous power-up stand-in |
| cfg_ff_type | input | 2 | 0 D, 1 T, 2 JK, 3 SR |
| cfg_bypass | input | 1 | 1: output is the combinational input |
| cfg_clk_mode | input | 2 | 0 global, 1 global with enable, 2/3 array clock |
| cfg_gsrc_sel | input | GSEL_W | Which global clock source is used |
| cfg_src_pin | input | GSRC_COUNT*PSEL_W | Pin index for each global source |
| cfg_src_inv | input | GSRC_COUNT | Inversion for each global source |
| cfg_gclr_en | input | 1 | Lets the global clear act on this cell |
| cfg_pwr_val | input | 1 | Value loaded at power-up |
| cfg_fast_in | input | 1 | Use `fast_pin` as D data |
| gclk_pin | input | GPIN_COUNT | Global clock pins |
| array_clk | input | 1 | Product-term clock |
| clk_en | input | 1 | Clock enable for mode 1 |
| lt_a | input | 1 | Logic-array data (D, T, J, S, bypass) |
| lt_b | input | 1 | Logic-array data (K, R) |
| fast_pin | input | 1 | Direct pin data |
| pt_preset | input | 1 | Active-high asynchronous preset |
| pt_clear | input | 1 | Active-high asynchronous clear |
| gclr_n | input | 1 | Active-low global clear |
| q | output | 1 | Cell output |

## Verification
The hardest case to reach is an active edge that arrives through an inverted global source on the non-default pin while the other pin also toggles. The cell must react to the falling edge of the selected pin and only to that. The stimulus picks source 1 on pin 1 in inverted form, pulses both pins in turn with changing data, and compares the output each cycle against a behavioural model.

A second hard case is an asynchronous clear and preset applied together in the same cycle as a clock edge. The stimulus overlaps them with clock pulses and then releases them without an edge, to show that the forced value is kept in the state.

// File: rtl/mcell_pkg.sv
// Package: shared encodings for the configurable logic-cell register.
// Assumes the configuration fields are held static between resets.
package mcell_pkg;

    typedef enum logic [1:0] {
        FF_D  = 2'd0,
        FF_T  = 2'd1,
        FF_JK = 2'd2,
        FF_SR = 2'd3
    } ff_kind_e;

    typedef enum logic [1:0] {
        CM_GLOBAL  = 2'd0,
        CM_GATED   = 2'd1,
        CM_ARRAY   = 2'd2,
        CM_ARRAY_B = 2'd3
    } clk_mode_e;

    // Width of an index over n items, at least one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mcell_clk_gen.sv
// Module: builds the global clock sources, picks the clock for the
// configured mode and turns its sampled rising edge into a one-cycle
// update strobe. Assumes every source is synchronous to clk.
module mcell_clk_gen
    import mcell_pkg::*;
#(
    parameter int GPIN_COUNT = 2,
    parameter int GSRC_COUNT = 2,
    parameter int PSEL_W     = 1,
    parameter int GSEL_W     = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   cfg_clk_mode,
    input  logic [GSEL_W-1:0]            cfg_gsrc_sel,
    input  logic [GSRC_COUNT*PSEL_W-1:0] cfg_src_pin,
    input  logic [GSRC_COUNT-1:0]        cfg_src_inv,
    input  logic [GPIN_COUNT-1:0]        gclk_pin,
    input  logic                         array_clk,
    input  logic                         clk_en,
    output logic                         tick
);

    logic [GSRC_COUNT-1:0] gsrc;
    logic                  sel_clk;
    logic                  sel_prev;
    logic                  en_ok;
    clk_mode_e             mode;

    // One polarity-selectable source per global clock.
    for (genvar g = 0; g < GSRC_COUNT; g++) begin : g_src
        assign gsrc[g] = gclk_pin[cfg_src_pin[g*PSEL_W +: PSEL_W]] ^ cfg_src_inv[g];
    end

    assign mode = clk_mode_e'(cfg_clk_mode);

    // Pick the clock signal and its enable for the configured mode.
    always_comb begin
        case (mode)
            CM_GLOBAL: begin sel_clk = gsrc[cfg_gsrc_sel]; en_ok = 1'b1;   end
            CM_GATED:  begin sel_clk = gsrc[cfg_gsrc_sel]; en_ok = clk_en; end
            default:   begin sel_clk = array_clk;          en_ok = 1'b1;   end
        endcase
    end

    // Remember the last sample of the chosen clock; reset seeds it with the current level.
    always_ff @(posedge clk) begin
        sel_prev <= sel_clk;
    end

    assign tick = rst_n & sel_clk & ~sel_prev & en_ok;

endmodule

// File: rtl/mcell_next.sv
// Module: next-state logic for the four flip-flop kinds and the
// fast pin path. Purely combinational.
module mcell_next
    import mcell_pkg::*;
(
    input  logic       cur,
    input  logic [1:0] cfg_ff_type,
    input  logic       cfg_fast_in,
    input  logic       lt_a,
    input  logic       lt_b,
    input  logic       fast_pin,
    output logic       nxt
);

    ff_kind_e kind;
    assign kind = ff_kind_e'(cfg_ff_type);

    // Value the state takes on an active edge.
    always_comb begin
        if (cfg_fast_in) begin
            nxt = fast_pin;
        end else begin
            case (kind)
                FF_D:  nxt = lt_a;
                FF_T:  nxt = cur ^ lt_a;
                FF_JK: nxt = (lt_a & ~cur) | (~lt_b & cur);
                FF_SR: nxt = (lt_a & ~lt_b) | (cur & ~(lt_b & ~lt_a));
                default: nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/mcell_async.sv
// Module: merges the local and global asynchronous controls into
// force-to-0 and force-to-1 with clear ahead of preset.
module mcell_async (
    input  logic pt_preset,
    input  logic pt_clear,
    input  logic gclr_n,
    input  logic cfg_gclr_en,
    output logic force_clr,
    output logic force_set
);

    // Clear from either source wins over preset.
    always_comb begin
        force_clr = pt_clear | (cfg_gclr_en & ~gclr_n);
        force_set = pt_preset & ~force_clr;
    end

endmodule

// File: rtl/mcell_reg.sv
// Module: top of the configurable logic-cell register. Holds the one
// state bit. Asynchronous controls override the output at once and
// are written into the state at the next clk edge. Assumes static
// configuration with a reset after every change.
module mcell_reg
    import mcell_pkg::*;
#(
    parameter  int GPIN_COUNT = 2,
    parameter  int GSRC_COUNT = 2,
    localparam int PSEL_W     = idx_w(GPIN_COUNT),
    localparam int GSEL_W     = idx_w(GSRC_COUNT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   cfg_ff_type,
    input  logic                         cfg_bypass,
    input  logic [1:0]                   cfg_clk_mode,
    input  logic [GSEL_W-1:0]            cfg_gsrc_sel,
    input  logic [GSRC_COUNT*PSEL_W-1:0] cfg_src_pin,
    input  logic [GSRC_COUNT-1:0]        cfg_src_inv,
    input  logic                         cfg_gclr_en,
    input  logic                         cfg_pwr_val,
    input  logic                         cfg_fast_in,
    input  logic [GPIN_COUNT-1:0]        gclk_pin,
    input  logic                         array_clk,
    input  logic                         clk_en,
    input  logic                         lt_a,
    input  logic                         lt_b,
    input  logic                         fast_pin,
    input  logic                         pt_preset,
    input  logic                         pt_clear,
    input  logic                         gclr_n,
    output logic                         q
);

    logic state;
    logic nxt;
    logic tick;
    logic force_clr;
    logic force_set;

    mcell_clk_gen #(
        .GPIN_COUNT(GPIN_COUNT),
        .GSRC_COUNT(GSRC_COUNT),
        .PSEL_W    (PSEL_W),
        .GSEL_W    (GSEL_W)
    ) u_clk (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_clk_mode(cfg_clk_mode),
        .cfg_gsrc_sel(cfg_gsrc_sel),
        .cfg_src_pin (cfg_src_pin),
        .cfg_src_inv (cfg_src_inv),
        .gclk_pin    (gclk_pin),
        .array_clk   (array_clk),
        .clk_en      (clk_en),
        .tick        (tick)
    );

    mcell_next u_next (
        .cur        (state),
        .cfg_ff_type(cfg_ff_type),
        .cfg_fast_in(cfg_fast_in),
        .lt_a       (lt_a),
        .lt_b       (lt_b),
        .fast_pin   (fast_pin),
        .nxt        (nxt)
    );

    mcell_async u_async (
        .pt_preset  (pt_preset),
        .pt_clear   (pt_clear),
        .gclr_n     (gclr_n),
        .cfg_gclr_en(cfg_gclr_en),
        .force_clr  (force_clr),
        .force_set  (force_set)
    );

    // State bit: power-up value, then forced values, then clocked update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= cfg_pwr_val;
        end else if (force_clr) begin
            state <= 1'b0;
        end else if (force_set) begin
            state <= 1'b1;
        end else if (tick) begin
            state <= nxt;
        end
    end

    // Output: bypass wire, or state with the immediate overrides applied.
    always_comb begin
        if (cfg_bypass)     q = lt_a;
        else if (force_clr) q = 1'b0;
        else if (force_set) q = 1'b1;
        else                q = state;
    end

endmodule

// File: rtl/mcell_reg_chk.sv
// Module: assertion checker for mcell_reg, bound to every instance.
module mcell_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_ff_type,
    input logic       cfg_bypass,
    input logic [1:0] cfg_clk_mode,
    input logic       cfg_gclr_en,
    input logic       cfg_pwr_val,
    input logic       cfg_fast_in,
    input logic       clk_en,
    input logic       lt_a,
    input logic       lt_b,
    input logic       pt_preset,
    input logic       pt_clear,
    input logic       gclr_n,
    input logic       q
);

    logic quiet;
    assign quiet = !pt_clear && !pt_preset && !(cfg_gclr_en && !gclr_n);

    assert_pwrup_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && quiet && !cfg_bypass) |-> (q == cfg_pwr_val));

    assert_sr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_ff_type == 2'd3 && !cfg_fast_in && !cfg_bypass
         && $past(lt_a && lt_b) && quiet && $past(quiet)) |-> (q == $past(q)));

    assert_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bypass |-> (q == lt_a));

    assert_gated_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_clk_mode == 2'd1 && !$past(clk_en) && !cfg_bypass
         && quiet && $past(quiet)) |-> (q == $past(q)));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_clear && !cfg_bypass) |-> !q);

    assert_preset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_preset && !pt_clear && !(cfg_gclr_en && !gclr_n) && !cfg_bypass) |-> q);

    assert_gclr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_gclr_en && !gclr_n && !cfg_bypass) |-> !q);

endmodule

bind mcell_reg mcell_reg_chk u_chk (.*);

// File: tb/sim_mcell_reg.sv
// Bench: drives configuration phases and compares q each clock with a
// behavioural model of the cell.
module sim_mcell_reg;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_ff_type, cfg_clk_mode, cfg_src_pin, cfg_src_inv, gclk_pin;
    logic [0:0] cfg_gsrc_sel;
    logic       cfg_bypass, cfg_gclr_en, cfg_pwr_val, cfg_fast_in;
    logic       array_clk, clk_en, lt_a, lt_b, fast_pin;
    logic       pt_preset, pt_clear, gclr_n, q;

    int    total = 0;
    int    bad   = 0;
    string tag   = "R1";
    bit    m_st  = 1'b0;
    bit    m_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcell_reg u0 (.*);

    function automatic bit m_clk();
        int s = int'(cfg_gsrc_sel);
        if (cfg_clk_mode >= 2) return array_clk;
        return gclk_pin[cfg_src_pin[s]] ^ cfg_src_inv[s];
    endfunction

    function automatic bit m_next();
        if (cfg_fast_in) return fast_pin;
        case (cfg_ff_type)
            2'd0: return lt_a;
            2'd1: return lt_a ? !m_st : m_st;
            2'd2: begin
                if (lt_a && lt_b) return !m_st;
                if (lt_a) return 1'b1;
                if (lt_b) return 1'b0;
                return m_st;
            end
            default: begin
                if (lt_a && !lt_b) return 1'b1;
                if (lt_b && !lt_a) return 1'b0;
                return m_st;
            end
        endcase
    endfunction

    function automatic bit m_out();
        bit clr = pt_clear || (cfg_gclr_en && !gclr_n);
        if (cfg_bypass) return lt_a;
        if (clr) return 1'b0;
        if (pt_preset) return 1'b1;
        return m_st;
    endfunction

    // One clock: advance the model at the edge, then compare away from it.
    task automatic tick();
        bit sc, clr, exp_q;
        @(posedge clk);
        sc  = m_clk();
        clr = pt_clear || (cfg_gclr_en && !gclr_n);
        if (!rst_n) m_st = cfg_pwr_val;
        else if (clr) m_st = 1'b0;
        else if (pt_preset) m_st = 1'b1;
        else if (sc && !m_prev && (cfg_clk_mode != 2'd1 || clk_en)) m_st = m_next();
        m_prev = sc;
        #2;
        exp_q = m_out();
        total++;
        if (q !== exp_q) begin
            bad++;
            $display("FAIL %s t=%0t q=%b expected=%b", tag, $time, q, exp_q);
        end
    endtask

    task automatic setup(input logic [1:0] ty, input logic [1:0] md,
                         input logic byp, input logic fast, input logic pwr);
        cfg_ff_type = ty; cfg_clk_mode = md; cfg_bypass = byp;
        cfg_fast_in = fast; cfg_pwr_val = pwr;
        rst_n = 1'b0; gclk_pin = 2'b00; array_clk = 1'b0; clk_en = 1'b0;
        lt_a = 1'b0; lt_b = 1'b0; fast_pin = 1'b0;
        pt_preset = 1'b0; pt_clear = 1'b0; gclr_n = 1'b1;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    // Pulse one clock signal: 0/1 = global pin, 2 = array clock.
    task automatic pulse(input int which);
        if (which == 2) array_clk = 1'b1; else gclk_pin[which] = 1'b1;
        tick();
        if (which == 2) array_clk = 1'b0; else gclk_pin[which] = 1'b0;
        tick();
    endtask

    initial begin
        cfg_src_pin = 2'b10; cfg_src_inv = 2'b00; cfg_gsrc_sel = 1'b0; cfg_gclr_en = 1'b1;

        tag = "R1"; setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);

        tag = "R2"; setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            lt_a = (8'b10110010 >> i) & 1'b1;
            pulse(0);
            lt_a = !lt_a; tick();
        end

        tag = "R3"; setup(2'd1, 2'd0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            lt_a = (8'b11011001 >> i) & 1'b1;
            pulse(0);
        end

        tag = "R4"; setup(2'd2, 2'd0, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) begin
            {lt_a, lt_b} = (16'b00_10_11_11_01_00_11_10 >> (2*i)) & 2'b11;
            pulse(0);
        end

        tag = "R5"; setup(2'd3, 2'd0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            {lt_a, lt_b} = (16'b10_11_01_11_00_10_00_11 >> (2*i)) & 2'b11;
            pulse(0);
        end

        tag = "R6"; setup(2'd0, 2'd0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            lt_a = i[0]; pt_preset = i[1]; pt_clear = (i == 4);
            pulse(0);
        end

        tag = "R7"; cfg_gsrc_sel = 1'b1; cfg_src_inv = 2'b10;
        setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            lt_a = !lt_a;
            pulse(0);
            pulse(1);
        end
        cfg_gsrc_sel = 1'b0; cfg_src_inv = 2'b00;

        tag = "R8"; setup(2'd1, 2'd1, 1'b0, 1'b0, 1'b0);
        lt_a = 1'b1;
        for (int i = 0; i < 8; i++) begin
            clk_en = (8'b01100101 >> i) & 1'b1;
            pulse(0);
        end

        tag = "R9"; setup(2'd1, 2'd2, 1'b0, 1'b0, 1'b0);
        lt_a = 1'b1;
        for (int i = 0; i < 4; i++) begin
            pulse(0); pulse(1); pulse(2);
        end

        tag = "R10"; setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
        lt_a = 1'b1; pulse(0);
        pt_clear = 1'b1; tick(); pt_clear = 1'b0; tick();
        pt_preset = 1'b1; tick(); pt_preset = 1'b0; tick();
        pt_clear = 1'b1; pt_preset = 1'b1; pulse(0);
        pt_clear = 1'b0; pt_preset = 1'b0; tick();
        lt_a = 1'b0; pt_preset = 1'b1; pulse(0); pt_preset = 1'b0; tick(); tick();

        tag = "R11"; setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
        gclr_n = 1'b0; tick(); gclr_n = 1'b1; tick();
        gclr_n = 1'b0; pt_preset = 1'b1; tick(); pt_preset = 1'b0; gclr_n = 1'b1; tick();
        cfg_gclr_en = 1'b0; setup(2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
        gclr_n = 1'b0; tick(); lt_a = 1'b0; pulse(0); lt_a = 1'b1; pulse(0); gclr_n = 1'b1;
        cfg_gclr_en = 1'b1;

        tag = "R12"; setup(2'd2, 2'd0, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) begin
            fast_pin = (6'b101100 >> i) & 1'b1;
            lt_a = 1'b1; lt_b = i[0];
            pulse(0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule